// File: doc/BRIEF.md
# Page-Mode NOR Flash Read Controller

This block sits between an on-chip requester and an asynchronous parallel NOR flash with a 16-bit data bus and a 22-bit word address. The requester hands over one word address at a time on a valid/ready channel. The block drives the flash chip-enable, output-enable, write-enable and address pins, waits the required access time, captures the data bus and returns the word on a second valid/ready channel. The flash comes out of reset already in its array-read state, so the block issues no command cycles. It never writes the device and never drives the data bus.

The flash groups words into pages of eight. The block keeps track of the page it has open. If a new request falls in that page while the bus is still enabled, only the low three address bits change and the shorter in-page wait applies. Any other access, including a change of page, the first access after reset and any access after the bus has been released, uses the full random-access wait. If no request arrives for a set number of cycles after a response, the block raises chip-enable and output-enable, which puts the device in standby and forgets the open page.

Back-pressure works as follows. A request transfers on a cycle where `req_valid` and `req_ready` are both high. Only one access can be outstanding, so `req_ready` stays low from acceptance until the response has been taken. A response transfers on a cycle where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values and the bus stays enabled with its address unchanged.

Top module: `nor_page_reader`

## Requirements
- R1: After reset, `fl_ce_n` and `fl_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `fl_we_n` is 1 on every cycle.
- R3: When no page is open, an accepted request raises `rsp_valid` on the cycle that follows RAND_WAIT full cycles of stable address with chip-enable and output-enable low, and `rsp_data` equals the flash word at that address.
- R4: When a page is open, a request whose address bits [21:3] match the open page raises `rsp_valid` after PAGE_WAIT cycles, with the correct data.
- R5: When a page is open, a request whose bits [21:3] differ from the open page uses the RAND_WAIT timing.
- R6: From acceptance until the response transfers, `fl_ce_n` and `fl_oe_n` stay 0 and `fl_addr` stays stable. `fl_addr` changes only on a request transfer.
- R7: After a response transfers, if no request is accepted in the next IDLE_LIMIT cycles, chip-enable and output-enable go high, the open page is dropped and the next access uses RAND_WAIT. A request accepted in the IDLE_LIMIT-th cycle still hits the page.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` stay unchanged.
- R9: `req_ready` is 0 whenever an access is in flight or a response is pending.
- R10: During a burst of same-page reads, bits [21:3] of `fl_addr` never change and chip-enable stays low between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 22 | Word address of the request |
| rsp_valid | output | 1 | Read word available |
| rsp_ready | input | 1 | Requester takes the word |
| rsp_data | output | 16 | Read word |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, held high |
| fl_addr | output | 22 | Flash word address |
| fl_dq | input | 16 | Flash data bus |

## Verification
Assertions check these on every cycle: the response stays stable under back-pressure, the address moves only on a request transfer, the upper address bits stay fixed across a page hit, the access counter steps down by one, the idle count stays bounded and an open page is dropped when the page is cleared. Only the bench scenarios can show that the waits are long enough. For that, a flash model drives garbage until both the page-level and word-level stability times have passed, and the bench measures request-to-response latency and checks the returned data. The bench scenarios also cover the exact idle-timeout boundary and the standby state after it.

// File: rtl/npr_pkg.sv
package npr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OPEN   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_RESP   = 2'd3
  } npr_state_e;
endpackage

// File: rtl/npr_page_tracker.sv
module npr_page_tracker #(
  parameter int AW = 22,
  parameter int PB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          clear,
  input  logic [AW-1:0] addr_in,
  output logic          hit,
  output logic          page_open
);
  localparam int TW = AW - PB;

  logic [TW-1:0] page_q;
  logic          vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      vld_q  <= 1'b0;
    end else if (capture) begin
      page_q <= addr_in[AW-1:PB];
      vld_q  <= 1'b1;
    end else if (clear) begin
      vld_q  <= 1'b0;
    end
  end

  assign hit       = vld_q && (addr_in[AW-1:PB] == page_q);
  assign page_open = vld_q;

  // R7: a cleared page is forgotten
  p_page_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !capture) |=> !page_open);
endmodule

// File: rtl/npr_wait_timer.sv
module npr_wait_timer #(
  parameter int RAND_WAIT = 7,
  parameter int PAGE_WAIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic short_sel,
  output logic expire
);
  localparam int TMAX = (RAND_WAIT > PAGE_WAIT) ? RAND_WAIT : PAGE_WAIT;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LONG_V  = CW'(RAND_WAIT);
  localparam logic [CW-1:0] SHORT_V = CW'(PAGE_WAIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= short_sel ? SHORT_V : LONG_V;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CW'(1));

  // R3/R4: a running count steps down by exactly one per cycle
  p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/npr_ctrl.sv
module npr_ctrl
  import npr_pkg::*;
#(
  parameter int IDLE_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_ready,
  input  logic wait_done,
  output logic req_ready,
  output logic accept,
  output logic rsp_valid,
  output logic capture_data,
  output logic page_clear,
  output logic bus_on
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_LIMIT - 1);

  npr_state_e st_q, st_d;
  logic [IW-1:0] idle_q;
  logic          bus_q;
  logic          gap_over;

  assign req_ready    = (st_q == ST_IDLE) || (st_q == ST_OPEN);
  assign accept       = req_valid && req_ready;
  assign rsp_valid    = (st_q == ST_RESP);
  assign capture_data = (st_q == ST_ACCESS) && wait_done;
  assign gap_over     = (st_q == ST_OPEN) && !accept && (idle_q == IDLE_LAST);
  assign page_clear   = gap_over;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = ST_ACCESS;
      ST_OPEN: begin
        if (accept)        st_d = ST_ACCESS;
        else if (gap_over) st_d = ST_IDLE;
      end
      ST_ACCESS: if (wait_done) st_d = ST_RESP;
      ST_RESP:   if (rsp_ready) st_d = ST_OPEN;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idle_q <= '0;
      bus_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      bus_q <= (st_d != ST_IDLE);
      if (st_d == ST_OPEN && st_q == ST_OPEN) idle_q <= idle_q + 1'b1;
      else                                     idle_q <= '0;
    end
  end

  assign bus_on = bus_q;

  // R7: the idle count never passes its limit
  p_idle_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q < IW'(IDLE_LIMIT));
  // R9: no request is taken while a response is pending
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R6: the bus is enabled whenever a response is held
  p_bus_on_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> bus_on);
endmodule

// File: rtl/nor_page_reader.sv
module nor_page_reader #(
  parameter int AW         = 22,
  parameter int DW         = 16,
  parameter int PAGE_BITS  = 3,
  parameter int RAND_WAIT  = 7,
  parameter int PAGE_WAIT  = 3,
  parameter int IDLE_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  input  logic [DW-1:0] fl_dq
);
  logic          accept, capture_data, page_clear, bus_on;
  logic          hit, page_open, wait_done;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  npr_ctrl #(.IDLE_LIMIT(IDLE_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .rsp_ready(rsp_ready), .wait_done(wait_done),
    .req_ready(req_ready), .accept(accept), .rsp_valid(rsp_valid),
    .capture_data(capture_data), .page_clear(page_clear), .bus_on(bus_on)
  );

  npr_page_tracker #(.AW(AW), .PB(PAGE_BITS)) u_page (
    .clk(clk), .rst_n(rst_n),
    .capture(accept), .clear(page_clear), .addr_in(req_addr),
    .hit(hit), .page_open(page_open)
  );

  npr_wait_timer #(.RAND_WAIT(RAND_WAIT), .PAGE_WAIT(PAGE_WAIT)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(accept), .short_sel(hit), .expire(wait_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (accept)       addr_q <= req_addr;
      if (capture_data) data_q <= fl_dq;
    end
  end

  assign fl_addr  = addr_q;
  assign fl_ce_n  = !bus_on;
  assign fl_oe_n  = !bus_on;
  assign fl_we_n  = 1'b1;
  assign rsp_data = data_q;

  // R8: a held response does not move
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R6: the address changes only on a request transfer
  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(fl_addr));
  // R10: a page hit keeps the upper address bits
  p_page_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (fl_addr[AW-1:PAGE_BITS] == $past(fl_addr[AW-1:PAGE_BITS])));
  // R4: a hit needs an open page with the bus enabled
  p_hit_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (page_open && bus_on));
endmodule

// File: tb/nor_page_reader_tb.sv
module nor_page_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22, DW = 16, TR = 7, TP = 3, IL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, fl_ce_n, fl_oe_n, fl_we_n;
  logic [DW-1:0] rsp_data, fl_dq;
  logic [AW-1:0] fl_addr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_page_reader #(.RAND_WAIT(TR), .PAGE_WAIT(TP), .IDLE_LIMIT(IL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq(fl_dq)
  );

  // Flash model: counts stable cycles of page bits and word bits
  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return (a[15:0] * 16'h9E37) ^ {10'd0, a[21:16]};
  endfunction

  int up_cnt = 0, lo_cnt = 0;
  logic [AW-1:0] prev_a = '0;
  int we_low = 0;
  always @(negedge clk) begin
    if (fl_we_n !== 1'b1) we_low++;
    if (fl_ce_n || fl_oe_n) begin up_cnt = 0; lo_cnt = 0; end
    else if (fl_addr[AW-1:3] != prev_a[AW-1:3] || up_cnt == 0) begin up_cnt = 1; lo_cnt = 1; end
    else if (fl_addr[2:0] != prev_a[2:0]) begin up_cnt++; lo_cnt = 1; end
    else begin up_cnt++; lo_cnt++; end
    prev_a = fl_addr;
  end
  assign fl_dq = (up_cnt >= TR && lo_cnt >= TP) ? pat(fl_addr) : ~pat(fl_addr);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one read; expects latency exp_w+1 negedges from acceptance
  task automatic do_read(input logic [AW-1:0] a, input int exp_w, input int hold, input string req);
    int lat = 1, bad = 0;
    logic [DW-1:0] held;
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid && lat < 50) begin
      if (req_ready || fl_ce_n || fl_oe_n || fl_addr != a) bad++;
      @(negedge clk); lat++;
    end
    chk(lat == exp_w + 1, {req, " latency"}, lat, exp_w + 1);
    chk(rsp_data == pat(a), {req, " data"}, rsp_data, pat(a));
    chk(bad == 0, "R6/R9 bus held, ready low during access", bad, 0);
    held = rsp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data != held || req_ready) bad++;
    end
    if (hold > 0) chk(bad == 0, "R8 response held under back-pressure", bad, 0);
    rsp_ready = 1'b1;
    @(negedge clk); rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(fl_ce_n && fl_oe_n, "R1 bus released at reset", {fl_ce_n, fl_oe_n}, 2'b11);
    chk(!rsp_valid && req_ready, "R1 handshake reset state", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic t_page_burst();
    logic [AW-1:3] up;
    int moved = 0;
    do_read(22'h12340, TR, 0, "R3 first access");
    up = fl_addr[AW-1:3];
    for (int w = 1; w < 8; w++) begin
      do_read(22'h12340 | AW'(w), TP, 0, "R4 in-page access");
      if (fl_addr[AW-1:3] != up || fl_ce_n) moved++;
    end
    chk(moved == 0, "R10 page bits fixed in burst", moved, 0);
  endtask

  task automatic t_page_miss();
    do_read(22'h2ABC5, TR, 0, "R5 page change");
    do_read(22'h2ABC2, TP, 3, "R4 hit after miss with back-pressure");
  endtask

  task automatic t_idle();
    // boundary: accepted in the last open cycle still hits
    repeat (IL - 2) @(negedge clk);
    chk(!fl_ce_n, "R7 bus still enabled before limit", fl_ce_n, 0);
    do_read(22'h2ABC7, TP, 0, "R7 hit at idle limit");
    repeat (IL) @(negedge clk);
    chk(fl_ce_n && fl_oe_n, "R7 standby after idle gap", {fl_ce_n, fl_oe_n}, 2'b11);
    do_read(22'h2ABC1, TR, 0, "R7 full wait after standby");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_page_burst();
        t_page_miss();
        t_idle();
        chk(we_low == 0, "R2 write enable high", we_low, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule